// File: doc/BRIEF.md
# RTC periodic interrupt flag controller

This block holds the interrupt status flags of a CMOS-style real-time clock and drives its interrupt line. Three event strobes feed it: a periodic tick, an alarm match and an update-ended event. Each one latches its own pending flag. When the matching enable bit in the control register is set, the event also sets a summary interrupt flag, and the level interrupt output follows that summary flag. A periodic tick can also produce a one-cycle pulse on a square-wave output. The pulse stands in for a true square wave, so the host never sees a fast toggling line.

Software reaches the block through a small register port. A write to the control register replaces the enable bits. At that moment the new enables are compared with the pending flags, so an event that is already waiting raises the interrupt at once. Writes to the status register, to the validity register and to the spare address change nothing. A status read clears every flag and drops the line. An event that arrives in the same cycle as the read is kept, so it is not lost.

In slew mode the block counts raised periodic ticks that the interrupt controller did not accept. These coalesced ticks can be reinjected later. A delivery acknowledge that arrives between ticks pays one of them back. The number of reinjections is counted up to a limit, and that count restarts at the next raised tick.

Top module: `rtc_irq_flags`

## Requirements
- R1: Each cycle with `tick_i` high sets the periodic flag, status bit 6, from the next cycle on. This holds whatever the enable bits are.
- R2: A tick while the periodic enable (control bit 6) is set also sets the summary flag, status bit 7, and raises `irq_o` in the next cycle.
- R3: A tick while square-wave enable (control bit 3) is set gives `sqw_o` high for exactly one cycle. With the bit clear, `sqw_o` stays low.
- R4: A control write (address 0) whose enable bits, control bits 6/5/4, overlap a pending flag (status bits 6/5/4: periodic, alarm, update) sets the summary flag and raises `irq_o` in the next cycle.
- R5: A control write whose enable bits match no pending flag clears the summary flag and lowers `irq_o`. The pending flags themselves are kept.
- R6: Writes to the status register (address 1), the validity register (address 2) and the spare address (3) leave `stat_o` and `irq_o` unchanged.
- R7: With `slew_i` high, a raised tick (tick with periodic enable set) while `ack_i` is low adds one to `coal_cnt_o`, saturating at its maximum. With `slew_i` low, or with `ack_i` high in the tick cycle, the count is unchanged.
- R8: With `slew_i` high, `ack_i` in a cycle without a tick, while `coal_cnt_o` is nonzero, lowers `coal_cnt_o` by one and raises `reinj_cnt_o` by one, up to REINJ_LIMIT. A raised slew tick that finds `reinj_cnt_o` at or above REINJ_LIMIT clears `reinj_cnt_o`.
- R9: A status read (`stat_rd_i`) clears the periodic, alarm, update and summary flags and lowers `irq_o` from the next cycle.
- R10: An event that coincides with a status read keeps its flag set after the read. It also keeps the summary flag and `irq_o` set if its enable bit is set.
- R11: While `rst_n` is low at a clock edge, all flags, both counters, `irq_o` and `sqw_o` clear to zero.
- R12: An alarm or update event sets its own flag, status bit 5 or bit 4. It raises `irq_o` only when its enable bit, control bit 5 or bit 4, is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Periodic tick strobe |
| alarm_i | input | 1 | Alarm match strobe |
| upd_i | input | 1 | Update-ended strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 status, 2 validity, 3 spare |
| reg_wdata_i | input | 8 | Register write data |
| stat_rd_i | input | 1 | Status read strobe (clear on read) |
| slew_i | input | 1 | Lost-tick slew mode enable |
| ack_i | input | 1 | Interrupt delivery acknowledge |
| irq_o | output | 1 | Level interrupt line |
| sqw_o | output | 1 | One-cycle square-wave pulse |
| stat_o | output | 8 | Status register: bit 7 summary, 6 periodic, 5 alarm, 4 update, 3:0 zero |
| coal_cnt_o | output | CNT_W | Coalesced tick count |
| reinj_cnt_o | output | $clog2(REINJ_LIMIT+1) | Reinjection count |

## Verification
The properties that relate a control write to the line assume that no event strobe fires in the same cycle as that write. The bench keeps control writes and events in separate cycles. The slew properties treat `ack_i` as a delivery acknowledge for a tick only when it is high in that tick's own cycle, and as a reinjection acknowledge only when it is high in a cycle without a tick. The stimulus drives both cases explicitly, one strobe per cycle, and returns every strobe to zero at the next falling edge.

// File: rtl/rtc_irq_pkg.sv
// Package: shared constants and address encoding for the RTC flag controller.
// Assumes an 8-bit status layout with the summary flag on top and the three
// event flags directly below it.
package rtc_irq_pkg;
    localparam int NFLAG    = 3;  // periodic, alarm, update
    localparam int FLAG_LSB = 4;  // event flags live in bits 6:4
    localparam int IRQF_BIT = 7;  // summary interrupt flag
    localparam int SQWE_BIT = 3;  // square-wave enable in the control byte
    localparam int PF_IDX   = 2;  // index of the periodic flag in the flag vector
    localparam int AF_IDX   = 1;
    localparam int UF_IDX   = 0;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_STAT  = 2'd1,
        ADDR_VALID = 2'd2,
        ADDR_SPARE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/rtc_flag_bank.sv
// Module: pending event flags plus the summary interrupt flag.
// Each event latches its own flag; a read clears all flags unless an event
// arrives in the same cycle. A control write re-evaluates the summary flag
// against the new enables; otherwise enabled events set it.
// Assumes control writes and events are not applied in the same cycle.
module rtc_flag_bank #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] ev_i,
    input  logic [NFLAG-1:0] en_q_i,
    input  logic             en_wr_i,
    input  logic [NFLAG-1:0] en_new_i,
    input  logic             rd_i,
    output logic [NFLAG-1:0] fl_o,
    output logic             irqf_o
);
    logic [NFLAG-1:0] fl_n;
    logic             irqf_n;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        // Next value of one flag: kept unless read, then OR in its event.
        always_comb fl_n[g] = (rd_i ? 1'b0 : fl_o[g]) | ev_i[g];

        // Register one pending flag.
        always_ff @(posedge clk) begin
            if (!rst_n) fl_o[g] <= 1'b0;
            else        fl_o[g] <= fl_n[g];
        end

        assert_event_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[g] |=> fl_o[g]);
    end

    // Summary flag: control write re-evaluates, otherwise enabled events add.
    always_comb begin
        if (en_wr_i) irqf_n = |(en_new_i & fl_n);
        else         irqf_n = (rd_i ? 1'b0 : irqf_o) | (|(ev_i & en_q_i));
    end

    // Register the summary flag.
    always_ff @(posedge clk) begin
        if (!rst_n) irqf_o <= 1'b0;
        else        irqf_o <= irqf_n;
    end

    assert_write_reeval_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i && (ev_i == '0) |=> irqf_o == |($past(en_new_i) & fl_o));
    assert_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i && (ev_i == '0) && ((en_new_i & fl_o) == '0) && !rd_i |=> !irqf_o);
endmodule

// File: rtl/rtc_sqw_pulse.sv
// Module: one-cycle square-wave pulse on each tick while enabled.
// Assumes the tick is already a single-cycle strobe.
module rtc_sqw_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sqwe_i,
    output logic sqw_o
);
    // Register the pulse so it follows the tick by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sqw_o <= 1'b0;
        else        sqw_o <= tick_i & sqwe_i;
    end

    assert_pulse_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && sqwe_i |=> sqw_o);
    assert_no_pulse_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !sqw_o);
endmodule

// File: rtl/rtc_coalesce_ctr.sv
// Module: lost-tick bookkeeping for slew mode.
// Counts raised ticks that were not acknowledged in their own cycle, pays one
// back on each acknowledge between ticks, and counts reinjections up to a
// limit; a raised tick at or above the limit restarts that count.
// Assumes ack_i in a tick cycle means the tick was delivered.
module rtc_coalesce_ctr #(
    parameter int CNT_W       = 8,
    parameter int REINJ_LIMIT = 4,
    localparam int RW         = $clog2(REINJ_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slew_i,
    input  logic             tick_i,
    input  logic             raise_i,
    input  logic             ack_i,
    output logic [CNT_W-1:0] coal_o,
    output logic [RW-1:0]    reinj_o
);
    localparam logic [CNT_W-1:0] COAL_MAX = '1;
    localparam logic [RW-1:0]    LIM      = RW'(REINJ_LIMIT);

    logic lost;
    logic repay;

    // Classify this cycle: undelivered tick, or a reinjection acknowledge.
    always_comb begin
        lost  = slew_i && raise_i && !ack_i;
        repay = slew_i && ack_i && !tick_i && (coal_o != '0);
    end

    // Coalesced tick counter, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                             coal_o <= '0;
        else if (lost && coal_o != COAL_MAX)    coal_o <= coal_o + 1'b1;
        else if (repay)                         coal_o <= coal_o - 1'b1;
    end

    // Reinjection counter: restarts on a raised tick once at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                             reinj_o <= '0;
        else if (slew_i && raise_i && reinj_o >= LIM) reinj_o <= '0;
        else if (repay && reinj_o < LIM)        reinj_o <= reinj_o + 1'b1;
    end

    assert_coal_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lost && coal_o != COAL_MAX |=> coal_o == $past(coal_o) + 1'b1);
    assert_coal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !slew_i |=> $stable(coal_o));
    assert_reinj_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slew_i && raise_i && reinj_o >= LIM |=> reinj_o == '0);
    assert_reinj_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> reinj_o <= LIM);
endmodule

// File: rtl/rtc_irq_flags.sv
// Module: top of the RTC periodic interrupt flag controller.
// Decodes register writes, holds the enable bits, and ties together the flag
// bank, the square-wave pulse and the slew-mode counters. Only control writes
// have an effect; the status, validity and spare addresses are read-only here.
module rtc_irq_flags
    import rtc_irq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int REINJ_LIMIT = 4,
    localparam int RW         = $clog2(REINJ_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             alarm_i,
    input  logic             upd_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    input  logic             stat_rd_i,
    input  logic             slew_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic             sqw_o,
    output logic [7:0]       stat_o,
    output logic [CNT_W-1:0] coal_cnt_o,
    output logic [RW-1:0]    reinj_cnt_o
);
    logic [NFLAG-1:0] en_q;
    logic [NFLAG-1:0] en_new;
    logic [NFLAG-1:0] ev;
    logic [NFLAG-1:0] fl;
    logic             sqwe_q;
    logic             ctl_wr;
    logic             irqf;
    logic             raise;
    logic             wdata_unused;

    // Decode the control write and collect the event strobes.
    always_comb begin
        ctl_wr         = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADDR_CTRL);
        en_new         = reg_wdata_i[FLAG_LSB +: NFLAG];
        ev             = '0;
        ev[PF_IDX]     = tick_i;
        ev[AF_IDX]     = alarm_i;
        ev[UF_IDX]     = upd_i;
        raise          = tick_i && en_q[PF_IDX];
    end

    assign wdata_unused = ^{reg_wdata_i[7], reg_wdata_i[2:0]};

    // Enable register: replaced on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            sqwe_q <= 1'b0;
        end else if (ctl_wr) begin
            en_q   <= en_new;
            sqwe_q <= reg_wdata_i[SQWE_BIT];
        end
    end

    rtc_flag_bank #(.NFLAG(NFLAG)) i_flag_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .en_q_i   (en_q),
        .en_wr_i  (ctl_wr),
        .en_new_i (en_new),
        .rd_i     (stat_rd_i),
        .fl_o     (fl),
        .irqf_o   (irqf)
    );

    rtc_sqw_pulse i_sqw_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .sqwe_i (sqwe_q),
        .sqw_o  (sqw_o)
    );

    rtc_coalesce_ctr #(.CNT_W(CNT_W), .REINJ_LIMIT(REINJ_LIMIT)) i_coalesce (
        .clk     (clk),
        .rst_n   (rst_n),
        .slew_i  (slew_i),
        .tick_i  (tick_i),
        .raise_i (raise),
        .ack_i   (ack_i),
        .coal_o  (coal_cnt_o),
        .reinj_o (reinj_cnt_o)
    );

    // Assemble the status byte and drive the line.
    always_comb begin
        stat_o                     = '0;
        stat_o[IRQF_BIT]           = irqf;
        stat_o[FLAG_LSB +: NFLAG]  = fl;
        irq_o                      = irqf;
    end

    assert_pie_tick_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && en_q[PF_IDX] && !ctl_wr |=> irq_o && stat_o[7]);
    assert_ro_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i && !ctl_wr && !stat_rd_i && ev == '0 |=> $stable(stat_o) && $stable(irq_o));
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_i && ev == '0 && !ctl_wr |=> stat_o == 8'h00 && !irq_o);
    assert_tick_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_i && tick_i |=> stat_o[6]);
    assert_alarm_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_i && !tick_i && !upd_i && !en_q[AF_IDX] && !irq_o && !ctl_wr && !stat_rd_i |=> !irq_o);
endmodule

// File: tb/test_rtc_irq_flags.sv
`timescale 1ns/1ps
module test_rtc_irq_flags;
    localparam int LIM = 2;
    localparam int RW  = $clog2(LIM + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 0, alarm_i = 0, upd_i = 0, reg_wr_i = 0, stat_rd_i = 0;
    logic slew_i = 0, ack_i = 0;
    logic [1:0] reg_addr_i = 0;
    logic [7:0] reg_wdata_i = 0;
    logic irq_o, sqw_o;
    logic [7:0] stat_o;
    logic [7:0] coal_cnt_o;
    logic [RW-1:0] reinj_cnt_o;

    always #2 clk = ~clk;

    rtc_irq_flags #(.CNT_W(8), .REINJ_LIMIT(LIM)) i_rtc_irq_flags (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .alarm_i(alarm_i), .upd_i(upd_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .stat_rd_i(stat_rd_i), .slew_i(slew_i), .ack_i(ack_i), .irq_o(irq_o),
        .sqw_o(sqw_o), .stat_o(stat_o), .coal_cnt_o(coal_cnt_o), .reinj_cnt_o(reinj_cnt_o)
    );

    typedef struct {
        logic [7:0]    stat;
        logic          irq;
        logic          sqw;
        logic [7:0]    coal;
        logic [RW-1:0] reinj;
        string         tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0]    e_stat = 0;
    logic          e_irq = 0, e_sqw = 0;
    logic [7:0]    e_coal = 0;
    logic [RW-1:0] e_reinj = 0;

    // Driver: queue the expectation for the coming edge, wait, return strobes to idle.
    task automatic go(input string tag);
        exp_t it;
        it.stat = e_stat; it.irq = e_irq; it.sqw = e_sqw;
        it.coal = e_coal; it.reinj = e_reinj; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        tick_i = 0; alarm_i = 0; upd_i = 0; reg_wr_i = 0; stat_rd_i = 0; ack_i = 0;
        e_sqw = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    endtask

    // Monitor: one cycle after each drive, compare outputs with the queued item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                total++;
                if (stat_o !== it.stat || irq_o !== it.irq || sqw_o !== it.sqw ||
                    coal_cnt_o !== it.coal || reinj_cnt_o !== it.reinj) begin
                    bad++;
                    $display("FAIL %s: stat=%h/%h irq=%b/%b sqw=%b/%b coal=%0d/%0d reinj=%0d/%0d (actual/expected)",
                             it.tag, stat_o, it.stat, irq_o, it.irq, sqw_o, it.sqw,
                             coal_cnt_o, it.coal, reinj_cnt_o, it.reinj);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        go("R11 reset state");
        go("R11 reset held");
        rst_n = 1;
        go("R11 idle after reset");

        tick_i = 1; e_stat = 8'h40; go("R1 tick sets PF with enables off");
        go("R1 PF holds");
        wr(2'd1, 8'hFF); go("R6 status write ignored");
        wr(2'd2, 8'hFF); go("R6 validity write ignored");
        wr(2'd3, 8'hFF); go("R6 spare write ignored");
        stat_rd_i = 1; e_stat = 8'h00; go("R9 read clears");

        wr(2'd0, 8'h40); go("R5 enable write with nothing pending");
        tick_i = 1; e_stat = 8'hC0; e_irq = 1; go("R2 enabled tick raises irq");
        stat_rd_i = 1; tick_i = 1; go("R10 tick wins over read");
        stat_rd_i = 1; e_stat = 8'h00; e_irq = 0; go("R9 read drops irq");

        wr(2'd0, 8'h00); go("R5 disable all");
        tick_i = 1; e_stat = 8'h40; go("R1 tick with PIE clear");
        wr(2'd0, 8'h40); e_stat = 8'hC0; e_irq = 1; go("R4 enable over pending PF");
        wr(2'd0, 8'h20); e_stat = 8'h40; e_irq = 0; go("R5 non-matching enable clears irq");
        alarm_i = 1; e_stat = 8'hE0; e_irq = 1; go("R12 alarm with AIE");
        stat_rd_i = 1; e_stat = 8'h00; e_irq = 0; go("R9 read clears all");
        upd_i = 1; e_stat = 8'h10; go("R12 update with UIE clear");
        wr(2'd0, 8'h10); e_stat = 8'h90; e_irq = 1; go("R4 enable over pending UF");
        stat_rd_i = 1; e_stat = 8'h00; e_irq = 0; go("R9 read after UF");

        wr(2'd0, 8'h08); go("R5 square wave enable only");
        tick_i = 1; e_stat = 8'h40; e_sqw = 1; go("R3 pulse on tick");
        go("R3 pulse lasts one cycle");
        stat_rd_i = 1; e_stat = 8'h00; go("R9 clear before slew");

        wr(2'd0, 8'h40); go("R5 PIE on");
        slew_i = 1;
        tick_i = 1; e_stat = 8'hC0; e_irq = 1; e_coal = 1; go("R7 undelivered tick counted");
        tick_i = 1; ack_i = 1; go("R7 delivered tick not counted");
        tick_i = 1; e_coal = 2; go("R7 second lost tick");
        ack_i = 1; e_coal = 1; e_reinj = 1; go("R8 reinject ack");
        ack_i = 1; e_coal = 0; e_reinj = 2; go("R8 reinject ack to limit");
        ack_i = 1; go("R8 ack with nothing coalesced");
        tick_i = 1; e_coal = 1; e_reinj = 0; go("R8 reinject count restarts at limit");
        slew_i = 0;
        tick_i = 1; go("R7 no counting outside slew");

        rst_n = 0; e_stat = 0; e_irq = 0; e_coal = 0; e_reinj = 0; go("R11 reset mid-run");
        rst_n = 1; go("R11 stays clear");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule